// File: doc/BRIEF.md
# CAN Standard Frame Transmitter with Bus Readback

This block sends one standard-format CAN data frame or remote frame onto a single-bit, logic-level, wired-AND bus. The frame content is a 11-bit identifier, a remote flag, a 4-bit length code and up to eight data bytes. It arrives through a valid/ready handshake and is held until it has been sent. Bits go out one per bit-time strobe, and at each strobe the block reads back the sampled bus level. From that readback it decides whether to keep driving, drop out because another node won arbitration, or abort on a bit error or a missing acknowledge.

A frame that lost arbitration or failed stays pending and is sent again once the bus has been idle for a fixed number of recessive samples. Bit stuffing is done by a neighbouring stuffer. The block tells the stuffer which bits are subject to stuffing. A strobe flagged as a stall is the stuffer's inserted bit: it is neither compared nor counted. Outcomes are single-cycle pulses: done, arbitration lost, bit error, acknowledge error.

Top module: `can_frame_tx`

## Requirements
- R1: `req_ready` is high exactly when no frame is pending. A frame is accepted on a cycle with `req_valid` and `req_ready` both high. While a frame is pending, new requests have no effect on the frame that is sent.
- R2: A transmission starts only after 11 consecutive strobes sample recessive (1) while the block is not driving. The first bit driven is a dominant (0) start bit.
- R3: The header after the start bit is: identifier bits 10..0, most significant first; then the remote bit (0 data, 1 remote); then two dominant bits; then the 4-bit length code, most significant first, sent as given.
- R4: A data frame carries min(length code, 8) bytes and a remote frame carries none. Data is sent from `req_data[63]` down, so byte 0 is `req_data[63:56]`.
- R5: After the data comes a 15-bit CRC, most significant first. It uses polynomial 0x4599 on a register cleared at the start bit, and it covers the start bit through the last data bit.
- R6: After the CRC come one recessive delimiter, a recessive ACK slot, a recessive ACK delimiter and 7 recessive end bits. `tx_done` pulses after the last end bit, and the pending frame is released.
- R7: In the identifier or remote bit, driving recessive but sampling dominant pulses `arb_lost`. The block stops driving (`frm_vld` low, `frm_bit` 1), and the frame stays pending.
- R8: Sampling recessive in the ACK slot pulses `ack_err` and aborts, with the frame still pending. Sampling dominant there continues the frame.
- R9: Any other difference between the driven and sampled bit pulses `bit_err` and aborts, with the frame still pending. This includes driving dominant but sampling recessive in the arbitration field.
- R10: A pending frame that lost arbitration or failed is sent again, complete, after the idle condition of R2 is met once more.
- R11: A strobe with `stuff_stall` high inside the stuffing region is neither compared nor counted. The bit being presented and the position in the frame stay unchanged.
- R12: `stuff_region` is high from the start bit through the last CRC bit and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_strobe | input | 1 | One-cycle pulse at each bit sample point |
| rx_bit | input | 1 | Sampled bus level (0 dominant) |
| stuff_stall | input | 1 | Current strobe carries a stuff bit |
| req_valid | input | 1 | Frame request valid |
| req_ready | output | 1 | No frame pending; request can be taken |
| req_id | input | 11 | Identifier |
| req_rtr | input | 1 | 1 for remote frame |
| req_dlc | input | 4 | Length code |
| req_data | input | 64 | Data bytes, byte 0 in bits 63:56 |
| frm_bit | output | 1 | Unstuffed bit to drive (1 when not sending) |
| frm_vld | output | 1 | Block is driving a frame |
| stuff_region | output | 1 | Present bit lies in the stuffed span |
| tx_done | output | 1 | Pulse: frame completed |
| arb_lost | output | 1 | Pulse: arbitration lost |
| bit_err | output | 1 | Pulse: bit error |
| ack_err | output | 1 | Pulse: no acknowledge |

## Verification
The hardest case to reach from the ports is losing arbitration exactly on the last identifier bit. The two frames must match through the start bit and ten identifier bits, and the idle count has to restart properly afterwards. The bench models the bus as the AND of the block's bit and a second node's bit sequence. It pits identifier 0x155 against 0x154, checks that the drop-out falls at bit position 11, and then counts the recessive strobes up to the retry. The same bus model can force a level at any bit position, which is how the bench produces a dominant-driven bit read back recessive inside the arbitration field.

// File: rtl/can_tx_pkg.sv
`timescale 1ns/1ps
package can_tx_pkg;

  localparam int CRC_W = 15;

  typedef enum logic [3:0] {
    PH_IDLE, PH_SOF, PH_ID, PH_RTR, PH_CTRL, PH_DATA,
    PH_CRC, PH_CDEL, PH_ACK, PH_ADEL, PH_EOF
  } phase_e;

  // One serial CRC step: feedback is the incoming bit against the top bit.
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic b,
                                                input logic [CRC_W-1:0] poly);
    logic fb;
    fb = b ^ c[CRC_W-1];
    crc_step = {c[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
  endfunction

  // Number of data bytes carried: none for remote, length code clamped to max.
  function automatic int payload_bytes(input logic [3:0] dlc, input logic rtr,
                                       input int max_bytes);
    if (rtr) payload_bytes = 0;
    else if (int'(dlc) > max_bytes) payload_bytes = max_bytes;
    else payload_bytes = int'(dlc);
  endfunction

endpackage

// File: rtl/can_crc15.sv
`timescale 1ns/1ps
module can_crc15
  import can_tx_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 15'h4599
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             shift_i,
  input  logic             din_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       crc_q <= '0;
    else if (clr_i)   crc_q <= '0;
    else if (en_i)    crc_q <= crc_step(crc_q, din_i, POLY);
    else if (shift_i) crc_q <= {crc_q[CRC_W-2:0], 1'b0};
  end

  assign crc_o = crc_q;

  // R5: a clear always leaves an all-zero register for the start bit
  p_crc_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (crc_o == '0));
endmodule

// File: rtl/can_idle_det.sv
`timescale 1ns/1ps
module can_idle_det #(
  parameter int IDLE_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  input  logic rx_i,
  input  logic hold_i,
  output logic idle_o
);
  localparam int CW = $clog2(IDLE_BITS + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (hold_i)   cnt_q <= '0;
    else if (strobe_i) begin
      if (!rx_i)                          cnt_q <= '0;
      else if (cnt_q != CW'(IDLE_BITS))   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign idle_o = (cnt_q == CW'(IDLE_BITS));

  // R2: a dominant sample always breaks the idle condition
  p_dom_breaks_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && !rx_i) |=> !idle_o);
  // R2: idle can only appear on a recessive sample strobe
  p_idle_on_rec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_o) |-> $past(strobe_i && rx_i && !hold_i));
endmodule

// File: rtl/can_tx_seq.sv
`timescale 1ns/1ps
module can_tx_seq
  import can_tx_pkg::*;
#(
  parameter int ID_W   = 11,
  parameter int DLC_W  = 4,
  parameter int DATA_W = 64,
  parameter int EOF_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic              bit_strobe_i,
  input  logic              stuff_stall_i,
  input  logic              rx_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic              rtr_i,
  input  logic [DLC_W-1:0]  dlc_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CRC_W-1:0]  crc_i,
  output logic              crc_clr_o,
  output logic              crc_en_o,
  output logic              crc_shift_o,
  output logic              crc_din_o,
  output logic              frm_bit_o,
  output logic              frm_vld_o,
  output logic              stuff_reg_o,
  output logic              done_o,
  output logic              lost_o,
  output logic              biterr_o,
  output logic              ackerr_o
);
  localparam int MAX_BYTES = DATA_W / 8;
  localparam int CTRL_W    = 2 + DLC_W;
  localparam int HDR_W     = 1 + ID_W + 1 + CTRL_W;
  localparam int CNT_W     = $clog2(DATA_W + CRC_W + 1);

  phase_e             phase_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [HDR_W-1:0]   hdr_q;
  logic [DATA_W-1:0]  dat_q;
  logic [CNT_W-1:0]   nbits;
  logic               cur_bit;

  // Internal events brought out as named wires
  logic start_ev, adv_ev, in_arb, lost_ev, ackmiss_ev, biterr_ev, abort_ev;
  logic last_ev, done_ev;

  function automatic logic [CNT_W-1:0] last_of(input phase_e p,
                                               input logic [CNT_W-1:0] nb);
    case (p)
      PH_ID:   last_of = CNT_W'(ID_W - 1);
      PH_CTRL: last_of = CNT_W'(CTRL_W - 1);
      PH_DATA: last_of = nb - 1'b1;
      PH_CRC:  last_of = CNT_W'(CRC_W - 1);
      PH_EOF:  last_of = CNT_W'(EOF_W - 1);
      default: last_of = '0;
    endcase
  endfunction

  function automatic phase_e next_of(input phase_e p, input logic has_data);
    case (p)
      PH_SOF:  next_of = PH_ID;
      PH_ID:   next_of = PH_RTR;
      PH_RTR:  next_of = PH_CTRL;
      PH_CTRL: next_of = has_data ? PH_DATA : PH_CRC;
      PH_DATA: next_of = PH_CRC;
      PH_CRC:  next_of = PH_CDEL;
      PH_CDEL: next_of = PH_ACK;
      PH_ACK:  next_of = PH_ADEL;
      PH_ADEL: next_of = PH_EOF;
      default: next_of = PH_IDLE;
    endcase
  endfunction

  assign nbits = CNT_W'(payload_bytes(4'(dlc_i), rtr_i, MAX_BYTES) * 8);

  always_comb begin
    case (phase_q)
      PH_SOF, PH_ID, PH_RTR, PH_CTRL: cur_bit = hdr_q[HDR_W-1];
      PH_DATA:                        cur_bit = dat_q[DATA_W-1];
      PH_CRC:                         cur_bit = crc_i[CRC_W-1];
      default:                        cur_bit = 1'b1;
    endcase
  end

  assign frm_vld_o   = (phase_q != PH_IDLE);
  assign frm_bit_o   = cur_bit;
  assign stuff_reg_o = (phase_q == PH_SOF) || (phase_q == PH_ID) ||
                       (phase_q == PH_RTR) || (phase_q == PH_CTRL) ||
                       (phase_q == PH_DATA) || (phase_q == PH_CRC);
  assign in_arb      = (phase_q == PH_ID) || (phase_q == PH_RTR);

  assign start_ev   = go_i && (phase_q == PH_IDLE);
  assign adv_ev     = bit_strobe_i && frm_vld_o && !(stuff_stall_i && stuff_reg_o);
  assign lost_ev    = adv_ev && in_arb && cur_bit && !rx_i;
  assign ackmiss_ev = adv_ev && (phase_q == PH_ACK) && rx_i;
  assign biterr_ev  = adv_ev && (phase_q != PH_ACK) && (cur_bit != rx_i) && !lost_ev;
  assign abort_ev   = lost_ev || ackmiss_ev || biterr_ev;
  assign last_ev    = (cnt_q == last_of(phase_q, nbits));
  assign done_ev    = adv_ev && !abort_ev && (phase_q == PH_EOF) && last_ev;

  assign crc_clr_o   = start_ev;
  assign crc_en_o    = adv_ev && stuff_reg_o && (phase_q != PH_CRC);
  assign crc_shift_o = adv_ev && (phase_q == PH_CRC);
  assign crc_din_o   = cur_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      hdr_q   <= '0;
      dat_q   <= '0;
    end else if (start_ev) begin
      phase_q <= PH_SOF;
      cnt_q   <= '0;
      hdr_q   <= {1'b0, id_i, rtr_i, 2'b00, dlc_i};
      dat_q   <= data_i;
    end else if (adv_ev) begin
      if (abort_ev) begin
        phase_q <= PH_IDLE;
        cnt_q   <= '0;
      end else begin
        if (phase_q == PH_SOF || phase_q == PH_ID ||
            phase_q == PH_RTR || phase_q == PH_CTRL)
          hdr_q <= {hdr_q[HDR_W-2:0], 1'b1};
        if (phase_q == PH_DATA)
          dat_q <= {dat_q[DATA_W-2:0], 1'b1};
        if (last_ev) begin
          phase_q <= next_of(phase_q, nbits != '0);
          cnt_q   <= '0;
        end else begin
          cnt_q   <= cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o   <= 1'b0;
      lost_o   <= 1'b0;
      biterr_o <= 1'b0;
      ackerr_o <= 1'b0;
    end else begin
      done_o   <= done_ev;
      lost_o   <= lost_ev;
      biterr_o <= biterr_ev;
      ackerr_o <= ackmiss_ev;
    end
  end

  // R6: at most one outcome per strobe
  p_single_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, lost_o, biterr_o, ackerr_o}));
  // R7: arbitration loss only comes out of the arbitration field
  p_lost_in_arb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lost_o |-> $past(phase_q == PH_ID || phase_q == PH_RTR));
  // R8: acknowledge error only comes out of the ACK slot
  p_ackerr_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ackerr_o |-> $past(phase_q == PH_ACK));
  // R6: completion only after the final end bit
  p_done_last_eof_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(phase_q == PH_EOF) && !frm_vld_o));
  // R11: a stalled strobe freezes the position and the presented bit
  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_strobe_i && stuff_stall_i && stuff_reg_o && !start_ev)
      |=> ($stable(phase_q) && $stable(cnt_q) && $stable(frm_bit_o)));
  // R7/R8/R9: after any abort the block no longer drives
  p_abort_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_o || biterr_o || ackerr_o) |-> (!frm_vld_o && frm_bit_o));
endmodule

// File: rtl/can_frame_tx.sv
`timescale 1ns/1ps
module can_frame_tx
  import can_tx_pkg::*;
#(
  parameter int ID_W      = 11,
  parameter int DLC_W     = 4,
  parameter int MAX_BYTES = 8,
  parameter int IDLE_BITS = 11,
  parameter int EOF_W     = 7,
  parameter logic [14:0] POLY = 15'h4599
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bit_strobe,
  input  logic                   rx_bit,
  input  logic                   stuff_stall,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ID_W-1:0]        req_id,
  input  logic                   req_rtr,
  input  logic [DLC_W-1:0]       req_dlc,
  input  logic [MAX_BYTES*8-1:0] req_data,
  output logic                   frm_bit,
  output logic                   frm_vld,
  output logic                   stuff_region,
  output logic                   tx_done,
  output logic                   arb_lost,
  output logic                   bit_err,
  output logic                   ack_err
);
  localparam int DATA_W = MAX_BYTES * 8;

  logic              pend_q;
  logic [ID_W-1:0]   id_q;
  logic              rtr_q;
  logic [DLC_W-1:0]  dlc_q;
  logic [DATA_W-1:0] dat_q;
  logic              bus_idle;
  logic              accept;
  logic              crc_clr, crc_en, crc_shift, crc_din;
  logic [CRC_W-1:0]  crc_val;

  assign req_ready = !pend_q;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      id_q   <= '0;
      rtr_q  <= 1'b0;
      dlc_q  <= '0;
      dat_q  <= '0;
    end else if (accept) begin
      pend_q <= 1'b1;
      id_q   <= req_id;
      rtr_q  <= req_rtr;
      dlc_q  <= req_dlc;
      dat_q  <= req_data;
    end else if (tx_done) begin
      pend_q <= 1'b0;
    end
  end

  can_idle_det #(.IDLE_BITS(IDLE_BITS)) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (bit_strobe),
    .rx_i     (rx_bit),
    .hold_i   (frm_vld),
    .idle_o   (bus_idle)
  );

  can_crc15 #(.POLY(POLY)) u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (crc_clr),
    .en_i    (crc_en),
    .shift_i (crc_shift),
    .din_i   (crc_din),
    .crc_o   (crc_val)
  );

  can_tx_seq #(
    .ID_W   (ID_W),
    .DLC_W  (DLC_W),
    .DATA_W (DATA_W),
    .EOF_W  (EOF_W)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .go_i          (pend_q && bus_idle && !tx_done),
    .bit_strobe_i  (bit_strobe),
    .stuff_stall_i (stuff_stall),
    .rx_i          (rx_bit),
    .id_i          (id_q),
    .rtr_i         (rtr_q),
    .dlc_i         (dlc_q),
    .data_i        (dat_q),
    .crc_i         (crc_val),
    .crc_clr_o     (crc_clr),
    .crc_en_o      (crc_en),
    .crc_shift_o   (crc_shift),
    .crc_din_o     (crc_din),
    .frm_bit_o     (frm_bit),
    .frm_vld_o     (frm_vld),
    .stuff_reg_o   (stuff_region),
    .done_o        (tx_done),
    .lost_o        (arb_lost),
    .biterr_o      (bit_err),
    .ackerr_o      (ack_err)
  );

  // R2: driving only ever begins out of an idle bus
  p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frm_vld) |-> $past(bus_idle));
  // R1: a request offered while pending leaves the held frame untouched
  p_hold_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && req_valid) |=> ($stable(id_q) && $stable(dat_q) && $stable(dlc_q)));
  // R10: a frame is never dropped by a failure, only by completion
  p_keep_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_lost || bit_err || ack_err) |-> !req_ready);
endmodule

// File: tb/can_frame_tx_tb.sv
`timescale 1ns/1ps
module can_frame_tx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_strobe = 1'b0;
  logic        stuff_stall = 1'b0;
  logic        req_valid = 1'b0;
  logic [10:0] req_id = '0;
  logic        req_rtr = 1'b0;
  logic [3:0]  req_dlc = '0;
  logic [63:0] req_data = '0;
  logic        other = 1'b1;
  logic        frc_en = 1'b0;
  logic        frc_lvl = 1'b1;
  logic        rx_bit;
  logic        req_ready, frm_bit, frm_vld, stuff_region;
  logic        tx_done, arb_lost, bit_err, ack_err;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic exp_b [0:127];
  int   exp_len, crc_last, ack_idx;
  int   crc_acc;
  bit   got_done, got_arb, got_bit, got_ack;
  int   end_idx;
  bit   p_done, p_arb, p_bit, p_ack;

  always #5 clk = ~clk;

  assign rx_bit = frc_en ? frc_lvl : (frm_vld ? (frm_bit & other) : other);

  can_frame_tx u_dut (
    .clk(clk), .rst_n(rst_n), .bit_strobe(bit_strobe), .rx_bit(rx_bit),
    .stuff_stall(stuff_stall), .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .req_rtr(req_rtr), .req_dlc(req_dlc), .req_data(req_data),
    .frm_bit(frm_bit), .frm_vld(frm_vld), .stuff_region(stuff_region),
    .tx_done(tx_done), .arb_lost(arb_lost), .bit_err(bit_err), .ack_err(ack_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Bench CRC, written as integer arithmetic
  task automatic put(input logic b, input bit in_crc);
    if (in_crc) begin
      int top;
      top = (crc_acc >> 14) & 1;
      crc_acc = (crc_acc << 1) & 32'h7FFF;
      if (top != int'(b)) crc_acc = crc_acc ^ 32'h4599;
    end
    exp_b[exp_len] = b;
    exp_len++;
  endtask

  task automatic build(input logic [10:0] id, input logic rtr,
                       input logic [3:0] dlc, input logic [63:0] d);
    int n, c;
    n = rtr ? 0 : ((dlc > 4'd8) ? 8 : int'(dlc));
    exp_len = 0;
    crc_acc = 0;
    put(1'b0, 1);
    for (int i = 10; i >= 0; i--) put(id[i], 1);
    put(rtr, 1);
    put(1'b0, 1);
    put(1'b0, 1);
    for (int i = 3; i >= 0; i--) put(dlc[i], 1);
    for (int i = 63; i >= 64 - 8 * n; i--) put(d[i], 1);
    c = crc_acc;
    for (int i = 14; i >= 0; i--) put(c[i], 0);
    crc_last = exp_len - 1;
    put(1'b1, 0);
    ack_idx = exp_len;
    put(1'b1, 0);
    put(1'b1, 0);
    for (int i = 0; i < 7; i++) put(1'b1, 0);
  endtask

  task automatic slot(input logic lvl, input logic stl, input logic fe, input logic fl);
    @(negedge clk);
    other = lvl; stuff_stall = stl; frc_en = fe; frc_lvl = fl; bit_strobe = 1'b1;
    @(negedge clk);
    bit_strobe = 1'b0; stuff_stall = 1'b0; frc_en = 1'b0; other = 1'b1;
    p_done = tx_done; p_arb = arb_lost; p_bit = bit_err; p_ack = ack_err;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic submit(input logic [10:0] id, input logic rtr,
                        input logic [3:0] dlc, input logic [63:0] d);
    @(negedge clk);
    req_id = id; req_rtr = rtr; req_dlc = dlc; req_data = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_start(input string req);
    int n = 0;
    while (!frm_vld && n < 40) begin
      slot(1'b1, 1'b0, 1'b0, 1'b1);
      n++;
    end
    chk(n == 11, req, "recessive strobes before start", n, 11);
  endtask

  // Run one attempt with the wired-AND bus model
  task automatic xfer(input bit arb_en, input logic [12:0] oth_hdr,
                      input int fault_idx, input logic fault_lvl,
                      input bit do_ack, input int stall_mod);
    int idx = 0;
    bit ended = 0;
    got_done = 0; got_arb = 0; got_bit = 0; got_ack = 0; end_idx = -1;
    for (int s = 0; s < 400 && !ended && frm_vld; s++) begin
      logic lvl, fb;
      bit stl;
      string tag;
      stl = (stall_mod != 0) && ((s % stall_mod) == stall_mod - 1) && (idx <= crc_last);
      fb = frm_bit;
      if (!stl) begin
        tag = (idx < 19) ? "R3" : (idx <= crc_last - 15) ? "R4" :
              (idx <= crc_last) ? "R5" : "R6";
        chk(frm_bit == exp_b[idx], tag, $sformatf("frame bit %0d", idx),
            frm_bit, exp_b[idx]);
        chk(stuff_region == (idx <= crc_last), "R12",
            $sformatf("stuff region at bit %0d", idx), stuff_region, idx <= crc_last);
      end
      lvl = 1'b1;
      if (arb_en && idx <= 12) lvl = oth_hdr[12-idx];
      if (do_ack && idx == ack_idx) lvl = 1'b0;
      if (stl) lvl = ~frm_bit;
      slot(lvl, stl, !stl && (idx == fault_idx), fault_lvl);
      if (stl) begin
        chk(frm_bit == fb && !(p_done | p_arb | p_bit | p_ack), "R11",
            "stall changed bit or raised outcome", frm_bit, fb);
      end else begin
        if (p_done | p_arb | p_bit | p_ack) begin
          ended = 1; end_idx = idx;
          got_done = p_done; got_arb = p_arb; got_bit = p_bit; got_ack = p_ack;
        end
        idx++;
      end
    end
  endtask

  task automatic expect_done(input string req);
    chk(got_done && !got_arb && !got_bit && !got_ack, req, "completion pulse",
        got_done, 1);
    chk(end_idx == exp_len - 1, req, "completion bit position", end_idx, exp_len - 1);
    chk(req_ready == 1'b1 && frm_vld == 1'b0, req, "ready after completion",
        req_ready, 1);
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(frm_vld == 1'b0 && frm_bit == 1'b1, "R2", "bus released after reset",
        {frm_vld, frm_bit}, 1);
    chk(stuff_region == 1'b0, "R12", "stuff region after reset", stuff_region, 0);
  endtask

  task automatic t_data_full;
    submit(11'h123, 1'b0, 4'd8, 64'hDEAD_BEEF_0123_4567);
    chk(req_ready == 1'b0, "R1", "ready low while pending", req_ready, 0);
    submit(11'h7FF, 1'b1, 4'd0, 64'h0);   // must be ignored
    build(11'h123, 1'b0, 4'd8, 64'hDEAD_BEEF_0123_4567);
    wait_start("R2");
    chk(frm_bit == 1'b0, "R2", "start bit dominant", frm_bit, 0);
    xfer(0, '0, -1, 1'b1, 1, 0);
    expect_done("R6");
  endtask

  task automatic t_remote;
    submit(11'h7F0, 1'b1, 4'd3, 64'hFFFF_0000_FFFF_0000);
    build(11'h7F0, 1'b1, 4'd3, 64'hFFFF_0000_FFFF_0000);
    wait_start("R2");
    xfer(0, '0, -1, 1'b1, 1, 0);
    expect_done("R4");
  endtask

  task automatic t_clamp_stall;
    submit(11'h2AA, 1'b0, 4'd12, 64'h0F1E_2D3C_4B5A_6978);
    build(11'h2AA, 1'b0, 4'd12, 64'h0F1E_2D3C_4B5A_6978);
    wait_start("R2");
    xfer(0, '0, -1, 1'b1, 1, 3);
    expect_done("R4");
  endtask

  task automatic t_dlc0;
    submit(11'h000, 1'b0, 4'd0, 64'hAAAA_AAAA_AAAA_AAAA);
    build(11'h000, 1'b0, 4'd0, 64'hAAAA_AAAA_AAAA_AAAA);
    wait_start("R2");
    xfer(0, '0, -1, 1'b1, 1, 0);
    expect_done("R5");
  endtask

  task automatic t_arb_lost;
    submit(11'h155, 1'b0, 4'd1, 64'h5A00_0000_0000_0000);
    build(11'h155, 1'b0, 4'd1, 64'h5A00_0000_0000_0000);
    wait_start("R2");
    xfer(1, {1'b0, 11'h154, 1'b0}, -1, 1'b1, 1, 0);
    chk(got_arb && !got_bit && !got_done, "R7", "arbitration lost pulse", got_arb, 1);
    chk(end_idx == 11, "R7", "loss position", end_idx, 11);
    chk(frm_vld == 1'b0 && frm_bit == 1'b1, "R7", "released after loss",
        {frm_vld, frm_bit}, 1);
    chk(req_ready == 1'b0, "R7", "frame still pending", req_ready, 0);
    wait_start("R10");
    xfer(0, '0, -1, 1'b1, 1, 0);
    expect_done("R10");
  endtask

  task automatic t_ack_err;
    submit(11'h321, 1'b0, 4'd2, 64'hC3A5_0000_0000_0000);
    build(11'h321, 1'b0, 4'd2, 64'hC3A5_0000_0000_0000);
    wait_start("R2");
    xfer(0, '0, -1, 1'b1, 0, 0);
    chk(got_ack && !got_bit, "R8", "ack error pulse", got_ack, 1);
    chk(end_idx == ack_idx, "R8", "ack error position", end_idx, ack_idx);
    chk(req_ready == 1'b0, "R8", "frame still pending", req_ready, 0);
    wait_start("R10");
    xfer(0, '0, -1, 1'b1, 1, 0);
    expect_done("R8");
  endtask

  task automatic t_bit_err;
    submit(11'h155, 1'b0, 4'd1, 64'h8100_0000_0000_0000);
    build(11'h155, 1'b0, 4'd1, 64'h8100_0000_0000_0000);
    wait_start("R2");
    xfer(0, '0, 0, 1'b1, 1, 0);            // start bit read back recessive
    chk(got_bit && end_idx == 0, "R9", "bit error on start bit", end_idx, 0);
    wait_start("R10");
    xfer(0, '0, 2, 1'b1, 1, 0);            // dominant id bit read back recessive
    chk(got_bit && !got_arb, "R9", "bit error in arbitration field", got_bit, 1);
    chk(end_idx == 2, "R9", "arbitration bit error position", end_idx, 2);
    wait_start("R10");
    xfer(0, '0, crc_last + 1, 1'b0, 1, 0); // delimiter read back dominant
    chk(got_bit && end_idx == crc_last + 1, "R9", "bit error on delimiter",
        end_idx, crc_last + 1);
    chk(req_ready == 1'b0, "R9", "frame still pending", req_ready, 0);
    wait_start("R10");
    xfer(0, '0, -1, 1'b1, 1, 0);
    expect_done("R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_data_full;
    t_remote;
    t_clamp_stall;
    t_dlc0;
    t_arb_lost;
    t_ack_err;
    t_bit_err;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule